// File: doc/BRIEF.md
# Byte FIFO Pair with Watermark, Overflow and Idle-Timeout Events

This block holds the two byte queues that sit between software and a serial bus controller. The format queue carries bytes from software towards the bus engine. The receive queue carries bytes from the bus engine back to software. Each queue is 32 entries deep. Each reports its level, full and empty state. Each can be emptied at once by a flush strobe.

Each queue has a programmable watermark. The first cycle the level reaches the programmed value raises an event pulse and sets a sticky interrupt flag. That flag holds until software clears it.

Other events:
- A write into a full queue is dropped and raises an overflow pulse.
- A read from an empty receive queue returns zero.
- An idle timer raises a timeout pulse when received bytes sit unread and no push or pop happens for a programmed number of cycles.

Every event output is a single-cycle pulse taken from the rising edge of its condition. A condition that persists is therefore reported only once.

Top module: `sbus_fifo_pair`

## Requirements
- R1: After reset both queues are empty with level 0, neither is full, no sticky flag is set, no event pulses, and the receive data output reads 0.
- R2: Each queue delivers bytes in the order they were accepted. The level counts the stored bytes, and the full flag is 1 exactly at 32 entries.
- R3: A push and a pop in the same cycle on a queue that is neither empty nor full leave the level unchanged, and the popped byte is the oldest one.
- R4: A push into a full queue is dropped, leaves the stored bytes and the level unchanged, and pulses that queue's overflow event in the same cycle. A run of back-to-back dropped pushes gives one pulse. A new run after a gap gives a new pulse.
- R5: A flush empties the queue so that none of the earlier bytes is delivered afterwards. A push in the same cycle as a flush is discarded.
- R6: The receive data output is 0 whenever the receive queue is empty, including after a flush. Popping an empty queue leaves the level at 0.
- R7: A watermark value of 0 disables that watermark. For a non-zero value, the cycle the level first becomes greater than or equal to it pulses the watermark event, and the sticky flag reads 1 from the next cycle.
- R8: A sticky watermark flag stays 1 while the level falls, until its clear strobe. A clear while the level is still at or above the watermark leaves the flag at 0 until the condition rises again. A set and a clear in the same cycle leave the flag set.
- R9: With the timeout enabled, a non-zero limit N and a non-empty receive queue, the timeout pulse appears N cycles after the last receive push or pop, exactly once.
- R10: Any accepted receive push or pop restarts the idle count. No timeout pulse occurs while the enable is 0, while the limit is 0, or while the receive queue is empty.
- R11: Every event output is high for at most one cycle per rising edge of its condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_push_i | input | 1 | Software writes a byte into the format queue |
| fmt_data_i | input | 8 | Byte written into the format queue |
| fmt_flush_i | input | 1 | Empties the format queue |
| fmt_pop_i | input | 1 | Bus engine takes the format queue head |
| fmt_head_o | output | 8 | Format queue head byte, 0 when empty |
| rx_push_i | input | 1 | Bus engine writes a received byte |
| rx_data_i | input | 8 | Received byte |
| rx_flush_i | input | 1 | Empties the receive queue |
| rx_pop_i | input | 1 | Software reads the receive queue head |
| rx_data_o | output | 8 | Receive queue head byte, 0 when empty |
| fmt_wm_lvl_i | input | 6 | Format watermark level, 0 disables |
| rx_wm_lvl_i | input | 6 | Receive watermark level, 0 disables |
| fmt_wm_clr_i | input | 1 | Clears the format sticky watermark flag |
| rx_wm_clr_i | input | 1 | Clears the receive sticky watermark flag |
| to_en_i | input | 1 | Enables the receive idle timer |
| to_limit_i | input | 16 | Idle cycles before timeout, 0 disables |
| fmt_level_o | output | 6 | Format queue level |
| rx_level_o | output | 6 | Receive queue level |
| fmt_full_o | output | 1 | Format queue full |
| rx_full_o | output | 1 | Receive queue full |
| fmt_empty_o | output | 1 | Format queue empty |
| rx_empty_o | output | 1 | Receive queue empty |
| fmt_wm_irq_o | output | 1 | Sticky format watermark flag |
| rx_wm_irq_o | output | 1 | Sticky receive watermark flag |
| fmt_wm_evt_o | output | 1 | Format watermark rising-edge pulse |
| rx_wm_evt_o | output | 1 | Receive watermark rising-edge pulse |
| fmt_ovf_evt_o | output | 1 | Format overflow pulse |
| rx_ovf_evt_o | output | 1 | Receive overflow pulse |
| rx_to_evt_o | output | 1 | Receive idle-timeout pulse |

## Verification
The hardest case to reach is the idle timeout at its exact cycle. It needs the enable on, bytes waiting and a quiet bus for exactly the programmed count, and then a single pulse despite the condition holding.

The stimulus loads a few received bytes with the timer enabled. It then idles while counting cycles from the last push, records where the first pulse lands and how many pulses occur, and repeats the same measurement after a single pop to show the restart. Overflow runs are reached by filling the receive queue to 32. Back-to-back and separated excess pushes follow, and the queue is then drained through the scoreboard to show that nothing was overwritten.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  // Event vector layout shared by the top and the edge detector.
  localparam int EV_FMT_WM  = 0;
  localparam int EV_RX_WM   = 1;
  localparam int EV_FMT_OVF = 2;
  localparam int EV_RX_OVF  = 3;
  localparam int EV_RX_TO   = 4;
  localparam int EV_NUM     = 5;
  // Queue indices for the watermark generate loop.
  localparam int Q_FMT = 0;
  localparam int Q_RX  = 1;
  localparam int Q_NUM = 2;
endpackage

// File: rtl/sbf_queue.sv
module sbf_queue #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic [LVL_W-1:0] level_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             drop_o,
  output logic             act_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic             wr_ok, rd_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (lvl_q == LVL_W'(DEPTH));
  assign empty_o = (lvl_q == '0);
  assign wr_ok   = wr_en_i & ~full_o & ~flush_i;
  assign rd_ok   = rd_en_i & ~empty_o & ~flush_i;
  assign drop_o  = wr_en_i & full_o & ~flush_i;
  assign act_o   = wr_ok | rd_ok;
  assign level_o = lvl_q;
  assign rd_data_o = empty_o ? '0 : mem_q[rptr_q];

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    lvl_d  = lvl_q;
    if (flush_i) begin
      wptr_d = '0;
      rptr_d = '0;
      lvl_d  = '0;
    end else begin
      if (wr_ok) wptr_d = ptr_inc(wptr_q);
      if (rd_ok) rptr_d = ptr_inc(rptr_q);
      case ({wr_ok, rd_ok})
        2'b10:   lvl_d = lvl_q + 1'b1;
        2'b01:   lvl_d = lvl_q - 1'b1;
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      lvl_q  <= lvl_d;
    end
  end

  // Storage has no reset; the empty mask hides stale contents.
  always_ff @(posedge clk_i) begin
    if (wr_ok) mem_q[wptr_q] <= wr_data_i;
  end

  a_r2_level_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= LVL_W'(DEPTH));
  a_r3_level_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && rd_en_i && !full_o && !empty_o && !flush_i) |=> $stable(lvl_q));
  a_r4_drop_keeps_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && full_o && !rd_en_i && !flush_i) |=> (full_o && $stable(lvl_q)));
  a_r5_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/sbf_idle_timer.sv
module sbf_idle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             armed_i,
  input  logic             kick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run;

  assign run = en_i & armed_i;

  always_comb begin
    cnt_d = cnt_q;
    if (!run || kick_i)        cnt_d = '0;
    else if (cnt_q < limit_i)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign expired_o = run & (limit_i != '0) & (cnt_q >= limit_i);

  a_r10_kick_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> !expired_o);
  a_r9_expiry_persists: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && en_i && armed_i && !kick_i && $stable(limit_i)) |=>
      (expired_o || !en_i || !armed_i || !$stable(limit_i)));
endmodule

// File: rtl/sbf_rise_detect.sv
module sbf_rise_detect #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] cond_i,
  output logic [N-1:0] pulse_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cond_i;
  end

  assign pulse_o = cond_i & ~prev_q;

  for (genvar g = 0; g < N; g++) begin : g_chk
    a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_o[g] |=> !pulse_o[g]);
  end
endmodule

// File: rtl/sbus_fifo_pair.sv
module sbus_fifo_pair
  import sbf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8,
  parameter int TO_W  = 16,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fmt_push_i,
  input  logic [WIDTH-1:0] fmt_data_i,
  input  logic             fmt_flush_i,
  input  logic             fmt_pop_i,
  output logic [WIDTH-1:0] fmt_head_o,
  input  logic             rx_push_i,
  input  logic [WIDTH-1:0] rx_data_i,
  input  logic             rx_flush_i,
  input  logic             rx_pop_i,
  output logic [WIDTH-1:0] rx_data_o,
  input  logic [LVL_W-1:0] fmt_wm_lvl_i,
  input  logic [LVL_W-1:0] rx_wm_lvl_i,
  input  logic             fmt_wm_clr_i,
  input  logic             rx_wm_clr_i,
  input  logic             to_en_i,
  input  logic [TO_W-1:0]  to_limit_i,
  output logic [LVL_W-1:0] fmt_level_o,
  output logic [LVL_W-1:0] rx_level_o,
  output logic             fmt_full_o,
  output logic             rx_full_o,
  output logic             fmt_empty_o,
  output logic             rx_empty_o,
  output logic             fmt_wm_irq_o,
  output logic             rx_wm_irq_o,
  output logic             fmt_wm_evt_o,
  output logic             rx_wm_evt_o,
  output logic             fmt_ovf_evt_o,
  output logic             rx_ovf_evt_o,
  output logic             rx_to_evt_o
);
  logic fmt_drop, rx_drop, fmt_act, rx_act, to_hit;
  logic [EV_NUM-1:0] cond, pulse;
  logic [LVL_W-1:0]  lvl   [Q_NUM];
  logic [LVL_W-1:0]  wmark [Q_NUM];
  logic [Q_NUM-1:0]  clr, irq_q, irq_d;

  sbf_queue #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_fmt (
    .clk_i, .rst_ni, .flush_i(fmt_flush_i), .wr_en_i(fmt_push_i),
    .wr_data_i(fmt_data_i), .rd_en_i(fmt_pop_i), .rd_data_o(fmt_head_o),
    .level_o(fmt_level_o), .full_o(fmt_full_o), .empty_o(fmt_empty_o),
    .drop_o(fmt_drop), .act_o(fmt_act)
  );

  sbf_queue #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rx (
    .clk_i, .rst_ni, .flush_i(rx_flush_i), .wr_en_i(rx_push_i),
    .wr_data_i(rx_data_i), .rd_en_i(rx_pop_i), .rd_data_o(rx_data_o),
    .level_o(rx_level_o), .full_o(rx_full_o), .empty_o(rx_empty_o),
    .drop_o(rx_drop), .act_o(rx_act)
  );

  sbf_idle_timer #(.CNT_W(TO_W)) u_timer (
    .clk_i, .rst_ni, .en_i(to_en_i), .armed_i(~rx_empty_o),
    .kick_i(rx_act), .limit_i(to_limit_i), .expired_o(to_hit)
  );

  assign lvl[Q_FMT]   = fmt_level_o;
  assign lvl[Q_RX]    = rx_level_o;
  assign wmark[Q_FMT] = fmt_wm_lvl_i;
  assign wmark[Q_RX]  = rx_wm_lvl_i;
  assign clr          = {rx_wm_clr_i, fmt_wm_clr_i};

  assign cond[EV_FMT_WM]  = (wmark[Q_FMT] != '0) && (lvl[Q_FMT] >= wmark[Q_FMT]);
  assign cond[EV_RX_WM]   = (wmark[Q_RX]  != '0) && (lvl[Q_RX]  >= wmark[Q_RX]);
  assign cond[EV_FMT_OVF] = fmt_drop;
  assign cond[EV_RX_OVF]  = rx_drop;
  assign cond[EV_RX_TO]   = to_hit;

  sbf_rise_detect #(.N(EV_NUM)) u_edges (
    .clk_i, .rst_ni, .cond_i(cond), .pulse_o(pulse)
  );

  // Sticky watermark flags: a set in the same cycle as a clear wins.
  for (genvar g = 0; g < Q_NUM; g++) begin : g_wm
    localparam int EV = (g == Q_FMT) ? EV_FMT_WM : EV_RX_WM;
    always_comb begin
      irq_d[g] = irq_q[g];
      if (clr[g])      irq_d[g] = 1'b0;
      if (pulse[EV])   irq_d[g] = 1'b1;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q[g] <= 1'b0;
      else         irq_q[g] <= irq_d[g];
    end
    a_r7_wm_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse[EV] |=> irq_q[g]);
    a_r8_wm_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_q[g] && !clr[g]) |=> irq_q[g]);
  end

  assign fmt_wm_irq_o  = irq_q[Q_FMT];
  assign rx_wm_irq_o   = irq_q[Q_RX];
  assign fmt_wm_evt_o  = pulse[EV_FMT_WM];
  assign rx_wm_evt_o   = pulse[EV_RX_WM];
  assign fmt_ovf_evt_o = pulse[EV_FMT_OVF];
  assign rx_ovf_evt_o  = pulse[EV_RX_OVF];
  assign rx_to_evt_o   = pulse[EV_RX_TO];

  a_r6_empty_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_o |-> (rx_data_o == '0));
  a_r10_no_timeout_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!to_en_i || rx_empty_o) |-> !rx_to_evt_o);
endmodule

// File: tb/sbus_fifo_pair_tb_top.sv
module sbus_fifo_pair_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 32;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       fmt_push_i, fmt_flush_i, fmt_pop_i;
  logic [7:0] fmt_data_i, fmt_head_o;
  logic       rx_push_i, rx_flush_i, rx_pop_i;
  logic [7:0] rx_data_i, rx_data_o;
  logic [5:0] fmt_wm_lvl_i, rx_wm_lvl_i, fmt_level_o, rx_level_o;
  logic       fmt_wm_clr_i, rx_wm_clr_i, to_en_i;
  logic [15:0] to_limit_i;
  logic fmt_full_o, rx_full_o, fmt_empty_o, rx_empty_o;
  logic fmt_wm_irq_o, rx_wm_irq_o, fmt_wm_evt_o, rx_wm_evt_o;
  logic fmt_ovf_evt_o, rx_ovf_evt_o, rx_to_evt_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] fmt_q[$];
  logic [7:0] rx_q[$];

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  sbus_fifo_pair dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  // Monitors: compare popped bytes with the scoreboard queues.
  always @(negedge clk_i) begin
    if (rst_ni && fmt_pop_i) begin
      logic [7:0] e;
      e = (fmt_q.size() > 0) ? fmt_q.pop_front() : 8'h00;
      check(fmt_head_o == e, "R2 fmt order", fmt_head_o, e);
    end
    if (rst_ni && rx_pop_i) begin
      logic [7:0] e;
      e = (rx_q.size() > 0) ? rx_q.pop_front() : 8'h00;
      check(rx_data_o == e, "R2/R6 rx order", rx_data_o, e);
    end
  end

  // Drivers: each updates the scoreboard as the design should.
  task automatic fmt_push(input logic [7:0] d, output bit ovf);
    fmt_push_i = 1; fmt_data_i = d; #1;
    ovf = fmt_ovf_evt_o;
    if (fmt_q.size() < DEPTH) fmt_q.push_back(d);
    tick(); fmt_push_i = 0;
  endtask

  task automatic rx_push(input logic [7:0] d, output bit ovf);
    rx_push_i = 1; rx_data_i = d; #1;
    ovf = rx_ovf_evt_o;
    if (rx_q.size() < DEPTH) rx_q.push_back(d);
    tick(); rx_push_i = 0;
  endtask

  task automatic fmt_pop();
    fmt_pop_i = 1; tick(); fmt_pop_i = 0;
  endtask

  task automatic rx_pop();
    rx_pop_i = 1; tick(); rx_pop_i = 0;
  endtask

  task automatic idle_watch(input int n, output int first, output int cnt);
    first = -1; cnt = 0;
    for (int i = 1; i <= n; i++) begin
      tick();
      if (rx_to_evt_o) begin
        if (first < 0) first = i;
        cnt++;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ov;
    int first, cnt;
    rst_ni = 0;
    fmt_push_i = 0; fmt_flush_i = 0; fmt_pop_i = 0; fmt_data_i = 0;
    rx_push_i = 0; rx_flush_i = 0; rx_pop_i = 0; rx_data_i = 0;
    fmt_wm_lvl_i = 0; rx_wm_lvl_i = 0; fmt_wm_clr_i = 0; rx_wm_clr_i = 0;
    to_en_i = 0; to_limit_i = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1;
    tick();

    // R1 reset state
    check(fmt_empty_o && rx_empty_o && !fmt_full_o && !rx_full_o, "R1 flags", fmt_empty_o, 1);
    check(fmt_level_o == 0 && rx_level_o == 0, "R1 levels", rx_level_o, 0);
    check(!fmt_wm_irq_o && !rx_wm_irq_o, "R1 sticky", rx_wm_irq_o, 0);
    check({fmt_wm_evt_o, rx_wm_evt_o, fmt_ovf_evt_o, rx_ovf_evt_o, rx_to_evt_o} == 0,
          "R1 events", rx_to_evt_o, 0);
    check(rx_data_o == 0, "R1 rx data", rx_data_o, 0);

    // R6 pop on empty
    rx_pop();
    check(rx_level_o == 0, "R6 empty pop level", rx_level_o, 0);

    // R2 order, fmt side
    for (int i = 0; i < 5; i++) fmt_push(8'(8'h10 + i * 3), ov);
    check(fmt_level_o == 5, "R2 fmt level", fmt_level_o, 5);
    for (int i = 0; i < 5; i++) fmt_pop();
    check(fmt_empty_o, "R2 fmt empty", fmt_empty_o, 1);

    // R3 simultaneous push and pop
    for (int i = 0; i < 3; i++) fmt_push(8'(8'h40 + i), ov);
    fmt_pop_i = 1; fmt_push_i = 1; fmt_data_i = 8'h77;
    fmt_q.push_back(8'h77);
    tick(); fmt_pop_i = 0; fmt_push_i = 0;
    check(fmt_level_o == 3, "R3 level steady", fmt_level_o, 3);
    for (int i = 0; i < 3; i++) fmt_pop();

    // R4 overflow on rx
    for (int i = 0; i < DEPTH; i++) begin
      rx_push(8'(i * 7 + 3), ov);
      if (ov) check(0, "R4 early ovf", 1, 0);
    end
    check(rx_full_o && rx_level_o == 32, "R2 rx full at 32", rx_level_o, 32);
    rx_push(8'hEE, ov);
    check(ov, "R4 ovf pulse", ov, 1);
    rx_push(8'hEF, ov);
    check(!ov, "R4/R11 consecutive drop one pulse", ov, 0);
    tick();
    rx_push(8'hF0, ov);
    check(ov, "R4 new run pulses", ov, 1);
    check(rx_level_o == 32, "R4 level kept", rx_level_o, 32);
    for (int i = 0; i < DEPTH; i++) rx_pop();
    check(rx_empty_o, "R4 drained", rx_empty_o, 1);

    // R5 flush beats push
    for (int i = 0; i < 10; i++) fmt_push(8'(8'h80 + i), ov);
    fmt_flush_i = 1; fmt_push_i = 1; fmt_data_i = 8'h5A;
    fmt_q.delete();
    tick(); fmt_flush_i = 0; fmt_push_i = 0;
    check(fmt_empty_o && fmt_level_o == 0, "R5 flush empties", fmt_level_o, 0);
    fmt_push(8'hA5, ov);
    check(fmt_head_o == 8'hA5, "R5 no stale byte", fmt_head_o, 8'hA5);
    fmt_pop();
    for (int i = 0; i < 4; i++) rx_push(8'(8'hC0 + i), ov);
    rx_flush_i = 1; rx_q.delete(); tick(); rx_flush_i = 0;
    check(rx_data_o == 0, "R6 zero after flush", rx_data_o, 0);
    rx_pop();

    // R7/R8 watermark
    rx_wm_lvl_i = 4;
    for (int i = 0; i < 3; i++) rx_push(8'(i + 1), ov);
    tick();
    check(!rx_wm_irq_o, "R7 below mark", rx_wm_irq_o, 0);
    rx_push_i = 1; rx_data_i = 8'h04; rx_q.push_back(8'h04);
    tick(); rx_push_i = 0;
    check(rx_wm_evt_o, "R7 event pulse", rx_wm_evt_o, 1);
    tick();
    check(rx_wm_irq_o, "R7 sticky set", rx_wm_irq_o, 1);
    check(!rx_wm_evt_o, "R11 wm pulse once", rx_wm_evt_o, 0);
    rx_pop(); rx_pop(); tick();
    check(rx_wm_irq_o, "R8 holds while level drops", rx_wm_irq_o, 1);
    rx_wm_clr_i = 1; tick(); rx_wm_clr_i = 0; tick();
    check(!rx_wm_irq_o, "R8 cleared", rx_wm_irq_o, 0);
    rx_push(8'h05, ov); rx_push(8'h06, ov); tick();
    check(rx_wm_irq_o, "R8 re-arm on new rise", rx_wm_irq_o, 1);
    rx_wm_clr_i = 1; tick(); rx_wm_clr_i = 0; tick(); tick();
    check(!rx_wm_irq_o, "R8 clear above mark stays 0", rx_wm_irq_o, 0);
    fmt_wm_lvl_i = 2;
    fmt_push(8'h11, ov); fmt_push(8'h22, ov); tick();
    check(fmt_wm_irq_o, "R7 fmt sticky", fmt_wm_irq_o, 1);
    fmt_pop(); fmt_pop();
    rx_flush_i = 1; rx_q.delete(); tick(); rx_flush_i = 0;
    rx_wm_lvl_i = 0;

    // R9/R10 idle timeout
    to_en_i = 1; to_limit_i = 20;
    for (int i = 0; i < 3; i++) rx_push(8'(8'h90 + i), ov);
    idle_watch(40, first, cnt);
    check(first == 20, "R9 timeout cycle", first, 20);
    check(cnt == 1, "R9/R11 single pulse", cnt, 1);
    rx_pop();
    idle_watch(40, first, cnt);
    check(first == 20 && cnt == 1, "R10 pop restarts", first, 20);
    to_en_i = 0;
    idle_watch(40, first, cnt);
    check(cnt == 0, "R10 disabled", cnt, 0);
    to_en_i = 1; to_limit_i = 0;
    idle_watch(40, first, cnt);
    check(cnt == 0, "R10 limit zero", cnt, 0);
    rx_pop(); rx_pop();
    to_limit_i = 5;
    idle_watch(20, first, cnt);
    check(cnt == 0, "R10 empty no timeout", cnt, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule